// File: doc/BRIEF.md
# Paired-Frame Translation Lookaside Buffer

This block is a small, fully associative translation cache. Each of its entries covers two neighbouring virtual pages, an even one and an odd one, under a single stored tag. It holds a separate physical frame number for each of the two pages, and each frame has its own valid and writable flag. Each entry also carries a page-size code of its own, so one buffer can hold 4 KB, 16 KB and 64 KB mappings side by side.

A lookup presents a virtual address and a load/store flag. One clock edge later the block returns the physical address together with exactly one status: hit, miss, invalid frame or write denied. A separate multi-match flag is raised alongside the status. Software loads an entry through a write port that names the slot index. Refill from page tables, address-space tags and memory behind the buffer are handled elsewhere.

Top module: `pair_tlb`

## Requirements
- R1: After a synchronous active-low reset, every output is 0 and every slot is empty, so the first lookups after reset report miss.
- R2: `rs_valid` repeats `lk_valid` one cycle later. When it is 1, exactly one of hit, miss, invalid and denied is 1. When it is 0, every status bit and `rs_pa` are 0.
- R3: The page-size code selects the bit that picks the frame: code 0 selects virtual-address bit 12 (4 KB), code 1 selects bit 14 (16 KB), and codes 2 and 3 both select bit 16 (64 KB).
- R4: `wr_tag` holds virtual-address bits 31..13. Only the tag bits above the select bit are compared with the address. Stored tag bits at or below the select bit are ignored.
- R5: On a match, a select bit of 0 picks the even frame and its flags, and a select bit of 1 picks the odd frame and its flags.
- R6: On a hit, `rs_pa` is the chosen frame number shifted left by 12. Every bit below the select bit is then replaced by the same virtual-address bit.
- R7: A slot whose two valid flags are both clear never matches. A lookup that matches no slot reports miss with `rs_pa` = 0.
- R8: A lookup that matches a slot whose chosen frame is not valid reports invalid (not miss), with `rs_pa` = 0.
- R9: A store to a valid frame that is not writable reports denied with `rs_pa` = 0. A load to the same frame is a hit.
- R10: When several slots match, the one with the lowest index supplies the result and `rs_multi` is 1. Otherwise `rs_multi` is 0.
- R11: A write replaces the whole slot. A lookup in the same cycle as the write still sees the old contents, and lookups from the next cycle see the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_va | input | 32 | Virtual address to translate |
| lk_store | input | 1 | 1 = store access, 0 = load |
| wr_en | input | 1 | Load a slot this cycle |
| wr_idx | input | 3 | Slot to load |
| wr_tag | input | 19 | Virtual address bits 31..13 of the page pair |
| wr_size | input | 2 | Page-size code (0: 4 KB, 1: 16 KB, 2/3: 64 KB) |
| wr_pfn_even | input | 20 | Frame number for the even page |
| wr_pfn_odd | input | 20 | Frame number for the odd page |
| wr_ok_even | input | 1 | Even frame valid |
| wr_rw_even | input | 1 | Even frame writable |
| wr_ok_odd | input | 1 | Odd frame valid |
| wr_rw_odd | input | 1 | Odd frame writable |
| rs_valid | output | 1 | Result present |
| rs_pa | output | 32 | Physical address (0 unless hit) |
| rs_hit | output | 1 | Translation succeeded |
| rs_miss | output | 1 | No slot matched |
| rs_invalid | output | 1 | Slot matched, chosen frame not valid |
| rs_denied | output | 1 | Store to a frame that is not writable |
| rs_multi | output | 1 | More than one slot matched |

## Verification
The bench builds the block with its defaults: eight slots, 32-bit virtual addresses and 20-bit frame numbers. With only eight slots, directed loads can fill every slot. The same directed loads can place two slots with the same tag for the priority case and mix all three page sizes, so that one address lands in both a small and a large mapping. A short pseudo-random phase then rewrites slots and looks up addresses around a handful of bases. This drives the offset splice at every select position, together with the read-during-write ordering.

// File: rtl/ptlb_pkg.sv
// Package ptlb_pkg
// Shared constants, enums and helpers for the paired-frame translation buffer.
// Assumes the smallest page is 4 KB and each size step multiplies the page by 4.
package ptlb_pkg;

    localparam int MIN_SHIFT = 12;
    localparam int SZ_W      = 2;
    localparam int SZ_STEP   = 2;
    localparam int REL_W     = 3;

    typedef enum logic [SZ_W-1:0] {
        PG_4K  = 2'd0,
        PG_16K = 2'd1,
        PG_64K = 2'd2
    } pg_size_e;

    typedef enum logic [1:0] {
        ST_MISS    = 2'd0,
        ST_INVALID = 2'd1,
        ST_DENIED  = 2'd2,
        ST_HIT     = 2'd3
    } lk_status_e;

    // Distance of the frame-select bit above MIN_SHIFT; codes above 64 KB clamp to 64 KB.
    function automatic logic [REL_W-1:0] size_rel(input logic [SZ_W-1:0] code);
        logic [SZ_W-1:0] k;
        k = (code > PG_64K) ? PG_64K : code;
        return REL_W'(int'(k) * SZ_STEP);
    endfunction

endpackage

// File: rtl/ptlb_entry.sv
// Module ptlb_entry
// One slot of the buffer. It stores a pair tag, a size code, two frames and their
// flags, and it presents a combinational match against the upper address bits.
// Assumes va_hi is address bit MIN_SHIFT and up, with the tag in va_hi[HI_W-1:1].
module ptlb_entry
    import ptlb_pkg::*;
#(
    parameter int HI_W  = 20,
    parameter int PFN_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [HI_W-2:0]   wr_tag,
    input  logic [SZ_W-1:0]   wr_size,
    input  logic [PFN_W-1:0]  wr_pfn_even,
    input  logic [PFN_W-1:0]  wr_pfn_odd,
    input  logic              wr_ok_even,
    input  logic              wr_rw_even,
    input  logic              wr_ok_odd,
    input  logic              wr_rw_odd,
    input  logic [HI_W-1:0]   va_hi,
    output logic              hit_tag,
    output logic [PFN_W-1:0]  pfn,
    output logic              fr_valid,
    output logic              fr_write,
    output logic [REL_W-1:0]  rel_shift
);
    localparam int TAG_W = HI_W - 1;

    logic [TAG_W-1:0]  tag_q;
    logic [SZ_W-1:0]   size_q;
    logic [PFN_W-1:0]  pfn_e_q, pfn_o_q;
    logic              ok_e_q, rw_e_q, ok_o_q, rw_o_q;
    logic [TAG_W-1:0]  care;
    logic              odd;

    // Slot storage: cleared by reset, fully replaced by a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q   <= '0;
            size_q  <= '0;
            pfn_e_q <= '0;
            pfn_o_q <= '0;
            ok_e_q  <= 1'b0;
            rw_e_q  <= 1'b0;
            ok_o_q  <= 1'b0;
            rw_o_q  <= 1'b0;
        end else if (wr_en) begin
            tag_q   <= wr_tag;
            size_q  <= wr_size;
            pfn_e_q <= wr_pfn_even;
            pfn_o_q <= wr_pfn_odd;
            ok_e_q  <= wr_ok_even;
            rw_e_q  <= wr_rw_even;
            ok_o_q  <= wr_ok_odd;
            rw_o_q  <= wr_rw_odd;
        end
    end

    // Masked tag compare and even/odd frame choice.
    always_comb begin
        rel_shift = size_rel(size_q);
        care      = {TAG_W{1'b1}} << rel_shift;
        hit_tag   = (ok_e_q | ok_o_q) &&
                    (((va_hi[HI_W-1:1] ^ tag_q) & care) == '0);
        odd       = va_hi[rel_shift];
        pfn       = odd ? pfn_o_q : pfn_e_q;
        fr_valid  = odd ? ok_o_q  : ok_e_q;
        fr_write  = odd ? rw_o_q  : rw_e_q;
    end

    // R11: one cycle after a write, the slot holds the written tag and size.
    a_r11_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> (tag_q == $past(wr_tag) && size_q == $past(wr_size)));

    // R7: a slot with both frames clear never reports a match.
    a_r7_empty_silent: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && !$past(wr_ok_even) && !$past(wr_ok_odd)) |-> !hit_tag);

endmodule

// File: rtl/ptlb_pick.sv
// Module ptlb_pick
// Priority selector over the slot match vector. The lowest index wins.
// It also flags when two or more slots match at once.
module ptlb_pick #(
    parameter int N_ENT = 8,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic [N_ENT-1:0] match,
    output logic [IDX_W-1:0] win,
    output logic             any,
    output logic             multi
);
    // Scan from the top index down so that the lowest matching index is kept last.
    always_comb begin
        win = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (match[i]) win = IDX_W'(i);
        end
        any   = |match;
        multi = |(match & (match - N_ENT'(1)));
    end

endmodule

// File: rtl/pair_tlb.sv
// Module pair_tlb
// Fully associative translation buffer. Each slot maps an even/odd page pair
// onto two frames. Lookup is combinational from the address and the result is
// registered, so it appears one cycle after the request. Writes load one slot.
// Assumes VA_W > MIN_SHIFT + 4 and PFN_W + MIN_SHIFT >= MIN_SHIFT + 4.
module pair_tlb
    import ptlb_pkg::*;
#(
    parameter int N_ENT = 8,
    parameter int VA_W  = 32,
    parameter int PFN_W = 20,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1,
    localparam int HI_W  = VA_W - MIN_SHIFT,
    localparam int TAG_W = HI_W - 1,
    localparam int PA_W  = PFN_W + MIN_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_va,
    input  logic              lk_store,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [SZ_W-1:0]   wr_size,
    input  logic [PFN_W-1:0]  wr_pfn_even,
    input  logic [PFN_W-1:0]  wr_pfn_odd,
    input  logic              wr_ok_even,
    input  logic              wr_rw_even,
    input  logic              wr_ok_odd,
    input  logic              wr_rw_odd,
    output logic              rs_valid,
    output logic [PA_W-1:0]   rs_pa,
    output logic              rs_hit,
    output logic              rs_miss,
    output logic              rs_invalid,
    output logic              rs_denied,
    output logic              rs_multi
);
    localparam int OFF_MAX = MIN_SHIFT + 2 * SZ_STEP;

    logic [N_ENT-1:0] e_match, e_fv, e_fw;
    logic [PFN_W-1:0] e_pfn [N_ENT];
    logic [REL_W-1:0] e_rel [N_ENT];

    logic [IDX_W-1:0] win;
    logic             any, multi;
    lk_status_e       st_c;
    logic [PA_W-1:0]  pa_c, base;
    logic [OFF_MAX-1:0] omask;

    // One storage slot per index, each with its own decoded write enable.
    for (genvar g = 0; g < N_ENT; g++) begin : g_slot
        ptlb_entry #(.HI_W(HI_W), .PFN_W(PFN_W)) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_en       (wr_en && (wr_idx == IDX_W'(g))),
            .wr_tag      (wr_tag),
            .wr_size     (wr_size),
            .wr_pfn_even (wr_pfn_even),
            .wr_pfn_odd  (wr_pfn_odd),
            .wr_ok_even  (wr_ok_even),
            .wr_rw_even  (wr_rw_even),
            .wr_ok_odd   (wr_ok_odd),
            .wr_rw_odd   (wr_rw_odd),
            .va_hi       (lk_va[VA_W-1:MIN_SHIFT]),
            .hit_tag     (e_match[g]),
            .pfn         (e_pfn[g]),
            .fr_valid    (e_fv[g]),
            .fr_write    (e_fw[g]),
            .rel_shift   (e_rel[g])
        );
    end

    ptlb_pick #(.N_ENT(N_ENT)) u_pick (
        .match (e_match),
        .win   (win),
        .any   (any),
        .multi (multi)
    );

    // Classify the winning slot and splice the page offset into its frame.
    always_comb begin
        if (!any)                                st_c = ST_MISS;
        else if (!e_fv[win])                     st_c = ST_INVALID;
        else if (lk_store && !e_fw[win])         st_c = ST_DENIED;
        else                                     st_c = ST_HIT;
        base  = {e_pfn[win], {MIN_SHIFT{1'b0}}};
        omask = (OFF_MAX'(1) << (MIN_SHIFT + int'(e_rel[win]))) - OFF_MAX'(1);
        pa_c  = base;
        pa_c[OFF_MAX-1:0] = (base[OFF_MAX-1:0] & ~omask) | (lk_va[OFF_MAX-1:0] & omask);
    end

    // Result register: one cycle after the request, zero when idle or not a hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_valid   <= 1'b0;
            rs_pa      <= '0;
            rs_hit     <= 1'b0;
            rs_miss    <= 1'b0;
            rs_invalid <= 1'b0;
            rs_denied  <= 1'b0;
            rs_multi   <= 1'b0;
        end else begin
            rs_valid   <= lk_valid;
            rs_hit     <= lk_valid && (st_c == ST_HIT);
            rs_miss    <= lk_valid && (st_c == ST_MISS);
            rs_invalid <= lk_valid && (st_c == ST_INVALID);
            rs_denied  <= lk_valid && (st_c == ST_DENIED);
            rs_multi   <= lk_valid && multi;
            rs_pa      <= (lk_valid && st_c == ST_HIT) ? pa_c : '0;
        end
    end

    // R2: a present result carries exactly one status.
    a_r2_one_status: assert property (@(posedge clk) disable iff (!rst_n)
        rs_valid |-> ($countones({rs_hit, rs_miss, rs_invalid, rs_denied}) == 1));

    // R2: an idle cycle leaves every result output at zero.
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_valid |-> (!rs_hit && !rs_miss && !rs_invalid && !rs_denied && !rs_multi && rs_pa == '0));

    // R2: the result follows the request by exactly one cycle.
    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lk_valid) |-> rs_valid);

    // R10: a multi-match implies at least one match, so it cannot be a miss.
    a_r10_multi_not_miss: assert property (@(posedge clk) disable iff (!rst_n)
        rs_multi |-> !rs_miss);

    // R9: a denied result only follows a store request.
    a_r9_denied_store: assert property (@(posedge clk) disable iff (!rst_n)
        rs_denied |-> $past(lk_store));

    // R6: the 4 KB offset always passes through untranslated on a hit.
    a_r6_offset_passes: assert property (@(posedge clk) disable iff (!rst_n)
        rs_hit |-> (rs_pa[MIN_SHIFT-1:0] == $past(lk_va[MIN_SHIFT-1:0])));

    // R7: a miss never carries an address.
    a_r7_miss_no_pa: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_miss || rs_invalid || rs_denied) |-> (rs_pa == '0));

endmodule

// File: tb/pair_tlb_tb.sv
`timescale 1ns/1ps
// Bench for pair_tlb: a behavioural model of the slot array, checked every clock.
module pair_tlb_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_va = '0;
    logic        lk_store = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [18:0] wr_tag = '0;
    logic [1:0]  wr_size = '0;
    logic [19:0] wr_pfn_even = '0, wr_pfn_odd = '0;
    logic        wr_ok_even = 1'b0, wr_rw_even = 1'b0, wr_ok_odd = 1'b0, wr_rw_odd = 1'b0;
    logic        rs_valid, rs_hit, rs_miss, rs_invalid, rs_denied, rs_multi;
    logic [31:0] rs_pa;

    always #4 clk = ~clk;

    pair_tlb u_dut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va), .lk_store(lk_store),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_size(wr_size),
        .wr_pfn_even(wr_pfn_even), .wr_pfn_odd(wr_pfn_odd),
        .wr_ok_even(wr_ok_even), .wr_rw_even(wr_rw_even),
        .wr_ok_odd(wr_ok_odd), .wr_rw_odd(wr_rw_odd),
        .rs_valid(rs_valid), .rs_pa(rs_pa), .rs_hit(rs_hit), .rs_miss(rs_miss),
        .rs_invalid(rs_invalid), .rs_denied(rs_denied), .rs_multi(rs_multi)
    );

    int vectors = 0;
    int fails   = 0;

    // Behavioural model of the slot contents.
    logic [18:0] m_tag [8];
    int          m_sz  [8];
    logic [19:0] m_pe  [8], m_po [8];
    bit          m_ve  [8], m_we [8], m_vo [8], m_wo [8];

    // Expected result vector: {valid, hit, miss, invalid, denied, multi, pa}.
    logic [37:0] exp_v;

    task automatic finish_up();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not end (actual hung, expected done)");
        finish_up();
    end

    task automatic model_lookup(input bit v, input logic [31:0] va, input bit st);
        int found = -1;
        int nm = 0;
        int s = 12;
        bit hit = 0, miss = 0, inv = 0, den = 0;
        logic [31:0] pa = '0;
        for (int e = 0; e < 8; e++) begin
            int se;
            logic [31:0] full;
            se = 12 + ((m_sz[e] >= 2) ? 4 : m_sz[e] * 2);
            full = {m_tag[e], 13'b0};
            if ((m_ve[e] || m_vo[e]) && ((va >> (se + 1)) == (full >> (se + 1)))) begin
                nm++;
                if (found < 0) begin
                    found = e;
                    s = se;
                end
            end
        end
        if (v) begin
            if (found < 0) miss = 1;
            else begin
                bit odd;
                bit fv, fw;
                logic [31:0] msk;
                odd = va[s];
                fv  = odd ? m_vo[found] : m_ve[found];
                fw  = odd ? m_wo[found] : m_we[found];
                if (!fv) inv = 1;
                else if (st && !fw) den = 1;
                else begin
                    hit = 1;
                    msk = (32'd1 << s) - 32'd1;
                    pa  = (({odd ? m_po[found] : m_pe[found], 12'b0}) & ~msk) | (va & msk);
                end
            end
        end
        exp_v = {v, hit, miss, inv, den, (v && nm > 1), pa};
    endtask

    // One clock: drive at the falling edge, model, then compare at the next falling edge.
    task automatic cycle(input string rq, input bit v, input logic [31:0] va, input bit st);
        logic [37:0] act;
        lk_valid = v;
        lk_va    = va;
        lk_store = st;
        model_lookup(v, va, st);
        if (wr_en) begin
            m_tag[wr_idx] = wr_tag;
            m_sz[wr_idx]  = int'(wr_size);
            m_pe[wr_idx]  = wr_pfn_even;
            m_po[wr_idx]  = wr_pfn_odd;
            m_ve[wr_idx]  = wr_ok_even;
            m_we[wr_idx]  = wr_rw_even;
            m_vo[wr_idx]  = wr_ok_odd;
            m_wo[wr_idx]  = wr_rw_odd;
        end
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        act = {rs_valid, rs_hit, rs_miss, rs_invalid, rs_denied, rs_multi, rs_pa};
        vectors++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s va=%h st=%0d: actual %h expected %h", rq, va, st, act, exp_v);
        end
    endtask

    task automatic load(input int idx, input logic [31:0] va_base, input int sz,
                        input logic [19:0] pe, input logic [19:0] po,
                        input bit ve, input bit we, input bit vo, input bit wo);
        wr_en = 1'b1;
        wr_idx = 3'(idx);
        wr_tag = va_base[31:13];
        wr_size = 2'(sz);
        wr_pfn_even = pe;
        wr_pfn_odd = po;
        wr_ok_even = ve;
        wr_rw_even = we;
        wr_ok_odd = vo;
        wr_rw_odd = wo;
    endtask

    logic [31:0] bases [6];
    logic [31:0] lcg = 32'h1234_5678;

    initial begin
        for (int e = 0; e < 8; e++) begin
            m_tag[e] = '0; m_sz[e] = 0; m_pe[e] = '0; m_po[e] = '0;
            m_ve[e] = 0; m_we[e] = 0; m_vo[e] = 0; m_wo[e] = 0;
        end
        // R1: outputs held at zero during reset.
        repeat (3) @(negedge clk);
        vectors++;
        if ({rs_valid, rs_hit, rs_miss, rs_invalid, rs_denied, rs_multi, rs_pa} !== 38'd0) begin
            fails++;
            $display("FAIL R1 reset outputs: actual %b expected 0", {rs_valid, rs_hit, rs_miss});
        end
        rst_n = 1'b1;
        cycle("R1", 1, 32'h0000_0000, 0);
        cycle("R1", 1, 32'h0040_0123, 1);

        // R11: a lookup in the write cycle sees the old (empty) slot.
        load(0, 32'h0040_0000, 0, 20'h12345, 20'h0ABCD, 1, 1, 1, 1);
        cycle("R11", 1, 32'h0040_0123, 0);
        cycle("R5", 1, 32'h0040_0123, 0);
        cycle("R6", 1, 32'h0040_1FFF, 1);
        cycle("R4", 1, 32'h0040_2000, 0);

        // R3/R4/R9: 16 KB slot, tag written with a don't-care bit 13 set.
        load(1, 32'h1000_2000, 1, 20'h20003, 20'h30000, 1, 1, 1, 0);
        cycle("R2", 0, 32'h1000_2345, 0);
        cycle("R4", 1, 32'h1000_2345, 0);
        cycle("R9", 1, 32'h1000_4010, 1);
        cycle("R9", 1, 32'h1000_4010, 0);
        cycle("R3", 1, 32'h1000_8000, 0);

        // R8: 64 KB slot with an invalid odd frame; R3 code 3 behaves as 64 KB.
        load(2, 32'h2000_0000, 2, 20'h40000, 20'h50000, 1, 1, 0, 0);
        cycle("R8", 1, 32'h2000_1234, 0);
        cycle("R8", 1, 32'h2001_1234, 0);
        load(3, 32'h3000_0000, 3, 20'h6000F, 20'h7000F, 1, 0, 1, 1);
        cycle("R3", 1, 32'h3000_ABCD, 0);
        cycle("R3", 1, 32'h3001_ABCD, 1);
        cycle("R9", 1, 32'h3000_0004, 1);

        // R10: two slots with the same tag; the lower index wins.
        load(5, 32'h5000_0000, 0, 20'h55555, 20'h55556, 1, 1, 1, 1);
        cycle("R10", 1, 32'h5000_0010, 0);
        load(4, 32'h5000_0000, 0, 20'h44444, 20'h44445, 1, 1, 1, 1);
        cycle("R10", 1, 32'h5000_0010, 0);
        cycle("R10", 1, 32'h5000_1010, 0);

        // R7: a slot with both frames clear never matches.
        load(6, 32'h6000_0000, 0, 20'h66666, 20'h66667, 0, 1, 0, 1);
        cycle("R7", 1, 32'h6000_0000, 0);
        cycle("R7", 1, 32'h6000_1000, 0);
        // R11: overwriting slot 0 empty removes its mapping.
        load(0, 32'h0040_0000, 0, 20'h0, 20'h0, 0, 0, 0, 0);
        cycle("R11", 1, 32'h0040_0123, 0);
        cycle("R11", 1, 32'h0040_0123, 0);
        cycle("R2", 0, 32'h1000_2345, 1);

        // Mixed phase: random slot rewrites and lookups around shared bases.
        bases[0] = 32'h0040_0000; bases[1] = 32'h1000_0000; bases[2] = 32'h2000_0000;
        bases[3] = 32'h3000_0000; bases[4] = 32'h5000_0000; bases[5] = 32'h0041_0000;
        for (int i = 0; i < 400; i++) begin
            logic [31:0] va;
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            if (lcg[31:29] == 3'd0) begin
                load(int'(lcg[2:0]), bases[lcg[27:25] % 6] | {lcg[24:23], 14'b0}, int'(lcg[22:21]),
                     lcg[20:1], ~lcg[19:0], lcg[8], lcg[9], lcg[10], lcg[11]);
            end
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            va = bases[lcg[31:29] % 6] | {14'b0, lcg[17:0]};
            cycle("R6", lcg[20] | lcg[21], va, lcg[22]);
        end
        finish_up();
    end

endmodule